// File: doc/BRIEF.md
# AES-128 Round Key Walker

This block supplies AES-128 round keys to a cipher datapath one full 128-bit key per clock, computing each key from the previous one instead of reading it from an expanded-key store. Four 32-bit word registers hold the current round key. A single transform path, made of a byte rotate, four S-box lookups and a round-constant XOR, serves both directions. A multiplexer on the direction picks which word feeds that path and which XOR chain rebuilds the next word set.

For encryption, a load captures the cipher key as round 0. Each step strobe then advances one round, up to round 10. For decryption, a load captures the cipher key and starts an automatic forward pass of ten cycles that stops on the round 10 key. From there each step strobe walks one round backward, down to the cipher key. A flag rises when the walk reaches its last key. Further strobes have no effect until the next load.

Top module: `aes128_key_walker`

## Requirements
- R1: While reset is high, and after it until the first load, `round_key` is all zeros, `round_idx` is 0 and `ready` is 0.
- R2: A `load` cycle captures `cipher_key` at the next edge: `round_key` then equals `cipher_key` (first 32-bit word in bits 127:96), `round_idx` is 0 and `ready` is 0. `load` takes priority over `step`, and it restarts any walk in progress.
- R3: In an encryption walk (`decrypt` low at load), each cycle with `step` high and `ready` low moves `round_key` to the next AES-128 expanded round key and increments `round_idx` by one at the next edge.
- R4: When `step` is low and no pre-scheduling pass is running, `round_key`, `round_idx` and `ready` hold their values.
- R5: An encryption walk ends at `round_idx` 10 with `ready` high. For cipher key 2b7e151628aed2a6abf7158809cf4f3c, the round 10 key is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R6: After a load with `decrypt` high, the block steps forward on its own, once per cycle, ignoring `step`. Exactly 10 edges after the load edge it shows the round 10 key with `round_idx` 10 and `ready` low.
- R7: In a decryption walk after the pass, each cycle with `step` high and `ready` low moves `round_key` to the previous round's key and decrements `round_idx` at the next edge.
- R8: A decryption walk ends at `round_idx` 0 with `round_key` equal to the loaded cipher key and `ready` high.
- R9: While `ready` is high, `step` has no effect on any output until the next load.
- R10: `round_idx` never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture cipher key and start a walk |
| cipher_key | input | 128 | Cipher key, first word in bits 127:96 |
| decrypt | input | 1 | Sampled on load: 1 selects the backward walk |
| step | input | 1 | Advance the walk by one round |
| round_key | output | 128 | Current round key |
| round_idx | output | 4 | Round number of `round_key`, 0 to 10 |
| ready | output | 1 | Last key of the walk reached |

## Verification
The walk is run with the published test key, with all-zero and all-one keys, and with a set of keys drawn from an arithmetic generator. Every round key in both directions is compared with an expansion computed in the bench from its own S-box. The all-zero and all-one keys stress the S-box at its fixed corners, and the test key pins the constant sequence against a known answer. Idle gaps inside a walk separate holding from stepping. Strobes held during the pre-scheduling pass and after the end show that those strobes are ignored, and a reload in mid-walk shows the restart.

// File: rtl/aks_pkg.sv
package aks_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int KEY_W     = WORD_W * NUM_WORDS;
    localparam int LAST_RND  = 10;
    localparam int RND_W     = $clog2(LAST_RND + 1);
    localparam logic [7:0] RCON_FIRST = 8'h01;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_ENC  = 2'd1,
        WALK_PRE  = 2'd2,
        WALK_DEC  = 2'd3
    } walk_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w3;
    } key_words_t;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_xtime_inv(input logic [7:0] a);
        return a[0] ? ({1'b1, 7'h00} | ((a ^ 8'h1b) >> 1)) : (a >> 1);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] res;
        sq  = a;
        res = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            res = gf_mul(res, sq);
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/kw_word_xform.sv
module kw_word_xform
    import aks_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [7:0]        rcon,
    output logic [WORD_W-1:0] word_out
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] rotated;
    logic [WORD_W-1:0] subbed;

    assign rotated = {word_in[WORD_W-9:0], word_in[WORD_W-1 -: 8]};

    for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
        assign subbed[b*8 +: 8] = sbox_fwd(rotated[b*8 +: 8]);
    end

    assign word_out = subbed ^ {rcon, {(WORD_W-8){1'b0}}};
endmodule

// File: rtl/kw_rcon_unit.sv
module kw_rcon_unit
    import aks_pkg::*;
(
    input  logic [7:0] rcon_q,
    output logic [7:0] rcon_next,
    output logic [7:0] rcon_prev
);
    assign rcon_next = gf_xtime(rcon_q);
    assign rcon_prev = gf_xtime_inv(rcon_q);
endmodule

// File: rtl/aes128_key_walker.sv
module aes128_key_walker
    import aks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [KEY_W-1:0]     cipher_key,
    input  logic                 decrypt,
    input  logic                 step,
    output logic [KEY_W-1:0]     round_key,
    output logic [RND_W-1:0]     round_idx,
    output logic                 ready
);
    key_words_t       kw_q;
    key_words_t       kw_fwd;
    key_words_t       kw_bwd;
    walk_mode_e       mode_q;
    logic [RND_W-1:0] rnd_q;
    logic [7:0]       rcon_q;
    logic [7:0]       rcon_next;
    logic [7:0]       rcon_prev;
    logic [7:0]       rcon_sel;
    logic [WORD_W-1:0] xf_in;
    logic [WORD_W-1:0] xf_out;
    logic [WORD_W-1:0] bwd_w3;
    logic             go_back;
    logic             at_end;

    kw_rcon_unit u_rcon (
        .rcon_q    (rcon_q),
        .rcon_next (rcon_next),
        .rcon_prev (rcon_prev)
    );

    assign go_back  = (mode_q == WALK_DEC);
    assign bwd_w3   = kw_q.w3 ^ kw_q.w2;
    assign xf_in    = go_back ? bwd_w3 : kw_q.w3;
    assign rcon_sel = go_back ? rcon_prev : rcon_q;

    kw_word_xform u_xform (
        .word_in  (xf_in),
        .rcon     (rcon_sel),
        .word_out (xf_out)
    );

    always_comb begin
        kw_fwd.w0 = kw_q.w0 ^ xf_out;
        kw_fwd.w1 = kw_q.w1 ^ kw_fwd.w0;
        kw_fwd.w2 = kw_q.w2 ^ kw_fwd.w1;
        kw_fwd.w3 = kw_q.w3 ^ kw_fwd.w2;
        kw_bwd.w3 = bwd_w3;
        kw_bwd.w2 = kw_q.w2 ^ kw_q.w1;
        kw_bwd.w1 = kw_q.w1 ^ kw_q.w0;
        kw_bwd.w0 = kw_q.w0 ^ xf_out;
    end

    always_comb begin
        case (mode_q)
            WALK_ENC: at_end = (rnd_q == RND_W'(LAST_RND));
            WALK_DEC: at_end = (rnd_q == '0);
            default:  at_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kw_q   <= '0;
            rnd_q  <= '0;
            rcon_q <= RCON_FIRST;
            mode_q <= WALK_IDLE;
        end else if (load) begin
            kw_q   <= cipher_key;
            rnd_q  <= '0;
            rcon_q <= RCON_FIRST;
            mode_q <= decrypt ? WALK_PRE : WALK_ENC;
        end else if (mode_q == WALK_PRE) begin
            kw_q   <= kw_fwd;
            rnd_q  <= rnd_q + 1'b1;
            rcon_q <= rcon_next;
            if (rnd_q == RND_W'(LAST_RND - 1)) mode_q <= WALK_DEC;
        end else if (step && !at_end) begin
            if (mode_q == WALK_ENC) begin
                kw_q   <= kw_fwd;
                rnd_q  <= rnd_q + 1'b1;
                rcon_q <= rcon_next;
            end else if (mode_q == WALK_DEC) begin
                kw_q   <= kw_bwd;
                rnd_q  <= rnd_q - 1'b1;
                rcon_q <= rcon_prev;
            end
        end
    end

    assign round_key = kw_q;
    assign round_idx = rnd_q;
    assign ready     = at_end;

    assert_round_range_R10: assert property (@(posedge clk) disable iff (rst)
        rnd_q <= RND_W'(LAST_RND));

    assert_load_restart_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (rnd_q == '0 && !ready && kw_q == $past(cipher_key)));

    assert_fwd_count_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WALK_ENC && step && !ready && !load) |=> rnd_q == $past(rnd_q) + 1'b1);

    assert_bwd_count_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WALK_DEC && step && !ready && !load) |=> rnd_q == $past(rnd_q) - 1'b1);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!step && !load && mode_q != WALK_PRE) |=> ($stable(kw_q) && $stable(rnd_q)));

    assert_end_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (ready && !load) |=> ($stable(kw_q) && ready));

    assert_pre_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WALK_PRE) |-> !ready);
endmodule

// File: tb/aes128_key_walker_bench.sv
module aes128_key_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [127:0] cipher_key = '0;
    logic         decrypt = 1'b0;
    logic         step = 1'b0;
    logic [127:0] round_key;
    logic [3:0]   round_idx;
    logic         ready;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0]   sb [256];
    logic [127:0] ref_keys [11];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes128_key_walker u_aes128_key_walker (
        .clk(clk), .rst(rst), .load(load), .cipher_key(cipher_key),
        .decrypt(decrypt), .step(step),
        .round_key(round_key), .round_idx(round_idx), .ready(ready)
    );

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic void build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv;
            logic [7:0] s;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (x != 0 && b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                       ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            sb[x] = s;
        end
    endfunction

    function automatic void expand(input logic [127:0] k);
        logic [31:0] w [44];
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
                rc = b_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++)
            ref_keys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [127:0] exp_key,
                         input int exp_idx, input logic exp_rdy);
        n_tests++;
        if (round_key !== exp_key || round_idx !== 4'(exp_idx) || ready !== exp_rdy) begin
            n_fail++;
            $display("FAIL %s: key=%h idx=%0d rdy=%b expected key=%h idx=%0d rdy=%b",
                     req, round_key, round_idx, ready, exp_key, exp_idx, exp_rdy);
        end
    endtask

    task automatic do_load(input logic [127:0] k, input logic dec, input logic stp);
        cipher_key = k; decrypt = dec; load = 1'b1; step = stp;
        tick();
        load = 1'b0; step = 1'b0;
    endtask

    task automatic enc_walk(input logic [127:0] k);
        expand(k);
        do_load(k, 1'b0, 1'b1);
        check("R2", ref_keys[0], 0, 1'b0);
        for (int r = 1; r <= 10; r++) begin
            step = 1'b1; tick(); step = 1'b0;
            check((r == 10) ? "R5" : "R3", ref_keys[r], r, r == 10);
            if (r == 5) begin
                tick(); tick();
                check("R4", ref_keys[5], 5, 1'b0);
            end
        end
        step = 1'b1; tick(); tick(); step = 1'b0;
        check("R9", ref_keys[10], 10, 1'b1);
    endtask

    task automatic dec_walk(input logic [127:0] k);
        expand(k);
        do_load(k, 1'b1, 1'b0);
        step = 1'b1;
        for (int c = 0; c < 9; c++) tick();
        step = 1'b0;
        tick();
        check("R6", ref_keys[10], 10, 1'b0);
        tick();
        check("R4", ref_keys[10], 10, 1'b0);
        for (int r = 9; r >= 0; r--) begin
            step = 1'b1; tick(); step = 1'b0;
            check((r == 0) ? "R8" : "R7", ref_keys[r], r, r == 0);
        end
        step = 1'b1; tick(); tick(); step = 1'b0;
        check("R9", k, 0, 1'b1);
    endtask

    initial begin
        logic [127:0] seed;
        build_sbox();
        tick(); tick();
        check("R1", '0, 0, 1'b0);
        rst = 1'b0;
        step = 1'b1; tick(); tick(); step = 1'b0;
        check("R1", '0, 0, 1'b0);

        expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
        n_tests++;
        if (ref_keys[10] !== 128'hd014f9a8c9ee2589e13f0cc8b6630ca6) begin
            n_fail++;
            $display("FAIL R5: bench expansion %h expected d014f9a8c9ee2589e13f0cc8b6630ca6",
                     ref_keys[10]);
        end

        enc_walk(128'h2b7e151628aed2a6abf7158809cf4f3c);
        dec_walk(128'h2b7e151628aed2a6abf7158809cf4f3c);
        enc_walk('0);
        dec_walk('0);
        enc_walk('1);
        dec_walk('1);

        seed = 128'h0123456789abcdeffedcba9876543210;
        for (int n = 0; n < 8; n++) begin
            seed = {seed[95:0], seed[127:96] * 32'd1103515245 + 32'd12345};
            enc_walk(seed);
            dec_walk(seed ^ {4{32'h5a5a_a5a5}});
        end

        // R2: reload in the middle of a walk restarts it
        expand(128'h000102030405060708090a0b0c0d0e0f);
        do_load(128'h000102030405060708090a0b0c0d0e0f, 1'b0, 1'b0);
        step = 1'b1; tick(); tick(); tick(); step = 1'b0;
        check("R3", ref_keys[3], 3, 1'b0);
        do_load(128'h000102030405060708090a0b0c0d0e0f, 1'b0, 1'b1);
        check("R2", ref_keys[0], 0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < MAX_CYCLES; c++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, idx=%0d expected completion", round_idx);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule